// File: doc/BRIEF.md
# Dual Programmable Ratio Divider

This block holds two programmable down-counters that run side by side. The reference counter divides a reference clock and produces the comparison pulse `frPulse`. The feedback counter divides a feedback clock and produces `fvPulse`. Both pulses feed a phase comparator. Each counter runs in its own clock domain. It takes its ratio from a 16-bit value that a separate serial loader holds steady. It emits one single-cycle pulse per period of N input clocks.

A ratio of zero does not divide. It stops the counter and raises a power-down indication. A zero reference ratio drops `oscEnable`, so the oscillator can be shut down. A zero feedback ratio raises `pumpFloat`, so the charge-pump outputs go to high impedance. When both ratios are zero, `lowPower` is raised. A nonzero ratio below a counter's legal minimum is treated as that minimum. A changed ratio is picked up only at the next terminal count, so the period in progress always completes at its old length.

Top module: `progDualDivider`

## Requirements
- R1: With a reference ratio N from 5 to 65535, `frPulse` is high for exactly one `refClk` cycle once every N `refClk` cycles.
- R2: With a feedback ratio N from 272 to 65535, `fvPulse` is high for exactly one `fbClk` cycle once every N `fbClk` cycles.
- R3: The two ratios act independently: changing one ratio leaves the pulse timing of the other counter unchanged.
- R4: A changed ratio is taken only when a pulse is issued. The period in progress ends with the old length, and the following period uses the new one.
- R5: A nonzero ratio below the counter's minimum is treated as the minimum. The minimum is 5 for the reference counter and 272 for the feedback counter.
- R6: While `refRatio` is zero, `oscEnable` is low and `frPulse` is low from the next `refClk` edge on. When a nonzero ratio returns, a pulse is issued at the first `refClk` edge that sees it, and counting restarts from there.
- R7: While `fbRatio` is zero, `pumpFloat` is high and `fvPulse` is low from the next `fbClk` edge on. Re-enabling the counter behaves as in R6, on `fbClk`.
- R8: `lowPower` is high exactly when both ratios are zero.
- R9: Each domain has a synchronous active-high reset. At the reset edge the counter clears and its pulse goes low. The first pulse comes at the first edge after release, provided the ratio is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| refRst | input | 1 | Synchronous active-high reset, reference domain |
| fbClk | input | 1 | Feedback clock |
| fbRst | input | 1 | Synchronous active-high reset, feedback domain |
| refRatio | input | 16 | Held reference divide ratio (0 = off) |
| fbRatio | input | 16 | Held feedback divide ratio (0 = off) |
| frPulse | output | 1 | Reference comparison pulse, refClk domain |
| fvPulse | output | 1 | Feedback comparison pulse, fbClk domain |
| oscEnable | output | 1 | High while the reference ratio is nonzero |
| pumpFloat | output | 1 | High while the feedback ratio is zero |
| lowPower | output | 1 | High while both ratios are zero |

## Verification
The assertions assume that each ratio is stable around the rising edge of its own clock domain. They also assume that a nonzero ratio never yields a period shorter than two cycles, and the clamp guarantees this. The bench changes `refRatio` only on falling edges of `refClk` and `fbRatio` only on falling edges of `fbClk`, so neither counter ever sees a ratio change at its sampling edge. The reset in each domain is also driven on that domain's falling edge. The flag outputs are compared shortly after a falling edge, once both ratio inputs have settled.

// File: rtl/divPkg.sv
`timescale 1ns/1ps
package divPkg;
  // Strobes issued by the control half to the counting datapath.
  typedef struct packed {
    logic clear;  // force the count to zero (reset or disabled)
    logic load;   // terminal count: reload with the next period
    logic dec;    // mid-period: count down by one
  } divStrobe_t;
endpackage

// File: rtl/divCtrl.sv
`timescale 1ns/1ps
module divCtrl #(
  parameter int WIDTH = 16,
  parameter int MIN_RATIO = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIDTH-1:0]     ratio,
  input  logic                 atZero,
  output divPkg::divStrobe_t   strobe,
  output logic [WIDTH-1:0]     loadVal,
  output logic                 pulse
);
  localparam logic [WIDTH-1:0] MIN_V = WIDTH'(MIN_RATIO);
  localparam logic [WIDTH-1:0] ONE_V = WIDTH'(1);

  logic enabled;
  logic [WIDTH-1:0] effRatio;

  assign enabled  = |ratio;
  assign effRatio = (ratio < MIN_V) ? MIN_V : ratio;
  assign loadVal  = effRatio - ONE_V;

  always_comb begin
    strobe.clear = rst | ~enabled;
    strobe.load  = ~strobe.clear & atZero;
    strobe.dec   = ~strobe.clear & ~atZero;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= strobe.load;
  end
endmodule

// File: rtl/divCount.sv
`timescale 1ns/1ps
module divCount #(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  divPkg::divStrobe_t strobe,
  input  logic [WIDTH-1:0]   loadVal,
  output logic               atZero
);
  logic [WIDTH-1:0] count;

  always_ff @(posedge clk) begin
    if (strobe.clear)     count <= '0;
    else if (strobe.load) count <= loadVal;
    else if (strobe.dec)  count <= count - WIDTH'(1);
  end

  assign atZero = (count == '0);
endmodule

// File: rtl/progDualDivider.sv
`timescale 1ns/1ps
module progDualDivider #(
  parameter int WIDTH   = 16,
  parameter int REF_MIN = 5,
  parameter int FB_MIN  = 272
) (
  input  logic             refClk,
  input  logic             refRst,
  input  logic             fbClk,
  input  logic             fbRst,
  input  logic [WIDTH-1:0] refRatio,
  input  logic [WIDTH-1:0] fbRatio,
  output logic             frPulse,
  output logic             fvPulse,
  output logic             oscEnable,
  output logic             pumpFloat,
  output logic             lowPower
);
  localparam int NUM_CH = 2;  // channel 0 = reference, 1 = feedback

  logic [NUM_CH-1:0] chClk, chRst, chPulse;
  logic [WIDTH-1:0]  chRatio [NUM_CH];

  assign chClk      = {fbClk, refClk};
  assign chRst      = {fbRst, refRst};
  assign chRatio[0] = refRatio;
  assign chRatio[1] = fbRatio;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int CH_MIN = (ch == 0) ? REF_MIN : FB_MIN;
    divPkg::divStrobe_t strobe;
    logic [WIDTH-1:0]   loadVal;
    logic               atZero;

    divCtrl #(.WIDTH(WIDTH), .MIN_RATIO(CH_MIN)) u_ctrl (
      .clk(chClk[ch]), .rst(chRst[ch]), .ratio(chRatio[ch]),
      .atZero(atZero), .strobe(strobe), .loadVal(loadVal),
      .pulse(chPulse[ch])
    );
    divCount #(.WIDTH(WIDTH)) u_count (
      .clk(chClk[ch]), .strobe(strobe), .loadVal(loadVal), .atZero(atZero)
    );
  end

  assign frPulse   = chPulse[0];
  assign fvPulse   = chPulse[1];
  assign oscEnable = |refRatio;
  assign pumpFloat = ~|fbRatio;
  assign lowPower  = ~oscEnable & pumpFloat;
endmodule

// File: rtl/divChecker.sv
`timescale 1ns/1ps
module divChecker #(
  parameter int WIDTH = 16
) (
  input logic             refClk,
  input logic             refRst,
  input logic             fbClk,
  input logic             fbRst,
  input logic [WIDTH-1:0] refRatio,
  input logic [WIDTH-1:0] fbRatio,
  input logic             frPulse,
  input logic             fvPulse,
  input logic             oscEnable,
  input logic             pumpFloat,
  input logic             lowPower
);
  // R1: reference pulse is one cycle wide
  p_fr_single_r1: assert property (@(posedge refClk) disable iff (refRst)
    frPulse |=> !frPulse);
  // R2: feedback pulse is one cycle wide
  p_fv_single_r2: assert property (@(posedge fbClk) disable iff (fbRst)
    fvPulse |=> !fvPulse);
  // R6: zero reference ratio silences the reference pulse
  p_fr_off_r6: assert property (@(posedge refClk) disable iff (refRst)
    (refRatio == '0) |=> !frPulse);
  // R7: zero feedback ratio silences the feedback pulse
  p_fv_off_r7: assert property (@(posedge fbClk) disable iff (fbRst)
    (fbRatio == '0) |=> !fvPulse);
  // R8: low power implies both individual off indications
  p_low_power_r8: assert property (@(posedge refClk) disable iff (refRst)
    lowPower |-> (pumpFloat && !oscEnable));
  // R9: reset edge clears each pulse
  p_fr_reset_r9: assert property (@(posedge refClk) refRst |=> !frPulse);
  p_fv_reset_r9: assert property (@(posedge fbClk) fbRst |=> !fvPulse);
endmodule

bind progDualDivider divChecker #(.WIDTH(WIDTH)) u_divChecker (
  .refClk(refClk), .refRst(refRst), .fbClk(fbClk), .fbRst(fbRst),
  .refRatio(refRatio), .fbRatio(fbRatio), .frPulse(frPulse),
  .fvPulse(fvPulse), .oscEnable(oscEnable), .pumpFloat(pumpFloat),
  .lowPower(lowPower)
);

// File: tb/tb_progDualDivider.sv
`timescale 1ns/1ps
module tb_progDualDivider;
  logic        refClk = 1'b0, fbClk = 1'b0;
  logic        refRst = 1'b1, fbRst = 1'b1;
  logic [15:0] refRatio = 16'd7, fbRatio = 16'd280;
  logic        frPulse, fvPulse, oscEnable, pumpFloat, lowPower;

  int    checks = 0, fails = 0;
  string refTag = "R9", fbTag = "R9";

  always #2 refClk = ~refClk;  // 250 MHz
  always #3 fbClk  = ~fbClk;

  progDualDivider dut (
    .refClk(refClk), .refRst(refRst), .fbClk(fbClk), .fbRst(fbRst),
    .refRatio(refRatio), .fbRatio(fbRatio), .frPulse(frPulse),
    .fvPulse(fvPulse), .oscEnable(oscEnable), .pumpFloat(pumpFloat),
    .lowPower(lowPower)
  );

  function automatic int clampTo(int r, int lo);
    return (r < lo) ? lo : r;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference-domain model: cycles since last pulse vs latched period
  int rSince = 0, rPer = 0; bit rArmed = 0, rExp = 0, rSeen = 0;
  always @(posedge refClk) begin
    if (refRst) begin rArmed = 0; rExp = 0; rSeen = 1; end
    else if (refRatio == 0) begin rArmed = 0; rExp = 0; end
    else if (!rArmed || rSince == rPer) begin
      rExp = 1; rPer = clampTo(int'(refRatio), 5); rSince = 1; rArmed = 1;
    end else begin rExp = 0; rSince++; end
  end

  // Feedback-domain model
  int fSince = 0, fPer = 0; bit fArmed = 0, fExp = 0, fSeen = 0;
  always @(posedge fbClk) begin
    if (fbRst) begin fArmed = 0; fExp = 0; fSeen = 1; end
    else if (fbRatio == 0) begin fArmed = 0; fExp = 0; end
    else if (!fArmed || fSince == fPer) begin
      fExp = 1; fPer = clampTo(int'(fbRatio), 272); fSince = 1; fArmed = 1;
    end else begin fExp = 0; fSince++; end
  end

  always @(negedge refClk) if (rSeen) check(refTag, "frPulse", frPulse, rExp);
  always @(negedge fbClk)  if (fSeen) check(fbTag, "fvPulse", fvPulse, fExp);

  // Flags are compared after both ratio inputs have settled
  always @(negedge refClk) begin
    #1;
    if (rSeen) begin
      check("R6", "oscEnable", oscEnable, refRatio != 0);
      check("R7", "pumpFloat", pumpFloat, fbRatio == 0);
      check("R8", "lowPower", lowPower, (refRatio == 0) && (fbRatio == 0));
    end
  end

  task automatic waitRef(int n);
    repeat (n) @(negedge refClk);
  endtask
  task automatic setRef(int v, string tag);
    @(negedge refClk); refRatio = 16'(v); refTag = tag;
  endtask
  task automatic setFb(int v, string tag);
    @(negedge fbClk); fbRatio = 16'(v); fbTag = tag;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    waitRef(3);
    @(negedge refClk); refRst = 1'b0; refTag = "R1";
    @(negedge fbClk);  fbRst  = 1'b0; fbTag  = "R2";
    waitRef(1200);
    // R4: ratio changes mid-period
    waitRef(3); setRef(11, "R4"); waitRef(80);
    setFb(300, "R4"); waitRef(1000);
    // R3: reference changes while feedback keeps running
    setRef(6, "R3"); fbTag = "R3"; waitRef(60);
    setRef(13, "R3"); waitRef(500);
    // R5: clamping below minimum
    setRef(3, "R5"); waitRef(40); setRef(1, "R5"); waitRef(30);
    setFb(10, "R5"); waitRef(1000); setFb(271, "R5"); waitRef(900);
    // R6: reference off and back on
    setRef(0, "R6"); waitRef(20); setRef(8, "R6"); waitRef(40);
    // R7: feedback off and back on
    setFb(0, "R7"); waitRef(60); setFb(272, "R7"); waitRef(1000);
    // R8: both off, then restore
    setRef(0, "R8"); setFb(0, "R8"); waitRef(40);
    setRef(9, "R8"); setFb(290, "R8"); waitRef(1000);
    // R9: mid-run resets in each domain
    @(negedge refClk); refRst = 1'b1; refTag = "R9"; waitRef(2);
    @(negedge refClk); refRst = 1'b0; waitRef(40);
    @(negedge fbClk); fbRst = 1'b1; fbTag = "R9"; repeat (2) @(negedge fbClk);
    @(negedge fbClk); fbRst = 1'b0; waitRef(1000);
    // R1 and R2: longer ratios
    setRef(1000, "R1"); waitRef(2600);
    setFb(2000, "R2"); waitRef(6500);
    summary();
    $finish;
  end
endmodule